// File: doc/BRIEF.md
# Ones-Density Monitor and Enforcer for a T1 Bit Stream

This block sits on a serial T1 data path that advances one bit per strobe. On every strobe it judges the incoming bit against the ones-density rules. A run of zeros must not grow past fifteen. For each N from 1 to 23, every stretch of 8·(N+1) consecutive bits must hold at least N ones. A broken rule sets a violation flag, which holds until a clear pulse arrives. Monitoring runs all the time and always judges the stream exactly as received.

An enforce input turns on a repair mode for the transmit direction. In this mode a zero is turned into a one when sending that zero would break a rule on the stream actually sent. Ones are never changed. The sent stream therefore meets every rule, whatever arrives at the input. With the mode off, the data passes through untouched. The mode should stay off for B8ZS-coded streams, which already meet the rules. The output is registered and lags the input by one strobe.

Top module: `ones_density_guard`

## Requirements
- R1: A strobe that carries the 16th consecutive zero of the received stream sets `viol_flag` at that strobe's clock edge. A 15th consecutive zero does not set it.
- R2: For every N in 1..23, a strobe that completes a stretch of 8·(N+1) received bits holding fewer than N ones sets `viol_flag`.
- R3: A stretch rule of length L is judged only once at least L bits have been strobed since reset. A stream of 15 zeros, then a one, then a one every 8th bit, raises no flag from reset onward.
- R4: `viol_flag` stays set until a one-cycle `viol_clr` clears it. If a violation and `viol_clr` come in the same strobe cycle, the flag ends up set.
- R5: With `enforce_en` low, `dout` takes the value of `din` at each strobe's clock edge.
- R6: With `enforce_en` high since reset, the bits sent on `dout` meet the rules of R1 and R2, judged as in R3, for any input.
- R7: With `enforce_en` high, a strobed one is sent as a one. A strobed zero is sent as a one only when sending a zero would break a rule of R1 or R2 on the sent stream.
- R8: `viol_flag` judges the received `din` stream and not the sent stream, whether `enforce_en` is high or low.
- R9: In a cycle without `bit_stb`, `dout` keeps its value and `viol_flag` keeps its value, except when `viol_clr` clears it.
- R10: After reset `dout` is 0, `viol_flag` is 0 and no bits count as seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_stb | input | 1 | Marks a cycle that carries a new stream bit |
| din | input | 1 | Received stream bit |
| enforce_en | input | 1 | 1 = repair the sent stream, 0 = pass through |
| viol_clr | input | 1 | One-cycle pulse that clears the violation flag |
| dout | output | 1 | Sent stream bit, one strobe behind the input |
| viol_flag | output | 1 | Sticky flag for a ones-density violation on the input |

## Verification
A running count that has drifted by even one shows up as a violation flag at the wrong strobe. The flag comes too early on a stream that sits right at a stretch's minimum, or is missing on a stream just below it. The error stays hidden until a stretch of that length next reaches its limit, which can take up to 192 strobes. In repair mode the same drift shows as a one forced where none was needed, or a zero let through that breaks a rule, at the first such strobe. Sparse random input in both modes, plus streams built to sit just on either side of one limit, brings these errors to the ports quickly.

// File: rtl/density_pkg.sv
package density_pkg;

    // Registered outputs of the top level
    typedef struct packed {
        logic line;   // bit last sent
        logic flag;   // sticky violation
    } guard_state_t;

endpackage

// File: rtl/density_window_track.sv
// History of one bit stream with a running ones count per stretch length.
// Reports whether the probe bit, taken as the next bit, would break a rule;
// on adv the committed bit is shifted in.
module density_window_track #(
    parameter int MAX_N   = 23,
    parameter int CELL    = 8,
    parameter int RUN_MAX = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic probe,
    input  logic bit_in,
    output logic viol
);
    localparam int HIST = CELL * (MAX_N + 1);
    localparam int CW   = $clog2(HIST + 1);
    localparam int RW   = $clog2(RUN_MAX + 2);

    typedef struct packed {
        logic [HIST-1:0]           hist;  // bit 0 newest
        logic [MAX_N-1:0][CW-1:0]  cnt;   // ones in each stretch
        logic [CW-1:0]             seen;  // saturating bit count
        logic [RW-1:0]             run;   // saturating zero run
    } trk_t;

    trk_t s_d, s_q;
    logic [MAX_N-1:0][CW-1:0] base;
    logic [CW-1:0] seen_n;
    logic [RW-1:0] run_z;

    always_comb begin
        s_d    = s_q;
        seen_n = (s_q.seen == CW'(HIST)) ? s_q.seen : s_q.seen + 1'b1;
        run_z  = (s_q.run == RW'(RUN_MAX + 1)) ? s_q.run : s_q.run + 1'b1;
        viol   = !probe && (run_z > RW'(RUN_MAX));
        for (int k = 0; k < MAX_N; k++) begin
            // drop the bit that leaves a stretch of CELL*(k+2) bits
            base[k] = s_q.cnt[k] - CW'(s_q.hist[CELL*(k+2)-1]);
            if (seen_n >= CW'(CELL * (k + 2))) begin
                if (base[k] + CW'(probe) < CW'(k + 1)) begin
                    viol = 1'b1;
                end
            end
        end
        if (adv) begin
            s_d.hist = {s_q.hist[HIST-2:0], bit_in};
            for (int k = 0; k < MAX_N; k++) begin
                s_d.cnt[k] = base[k] + CW'(bit_in);
            end
            s_d.seen = seen_n;
            s_d.run  = bit_in ? '0 : run_z;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/ones_density_guard.sv
module ones_density_guard #(
    parameter int MAX_N   = 23,
    parameter int CELL    = 8,
    parameter int RUN_MAX = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic din,
    input  logic enforce_en,
    input  logic viol_clr,
    output logic dout,
    output logic viol_flag
);
    import density_pkg::*;

    guard_state_t s_d, s_q;
    logic rx_bad;     // received bit breaks a rule
    logic tx_zbad;    // a zero on the sent stream would break a rule
    logic tx_bit;

    // judges the stream as received
    density_window_track #(.MAX_N(MAX_N), .CELL(CELL), .RUN_MAX(RUN_MAX)) rx_trk (
        .clk(clk), .rst_n(rst_n), .adv(bit_stb),
        .probe(din), .bit_in(din), .viol(rx_bad)
    );

    // follows the stream as sent
    density_window_track #(.MAX_N(MAX_N), .CELL(CELL), .RUN_MAX(RUN_MAX)) tx_trk (
        .clk(clk), .rst_n(rst_n), .adv(bit_stb),
        .probe(1'b0), .bit_in(tx_bit), .viol(tx_zbad)
    );

    assign tx_bit = din | (enforce_en & tx_zbad);

    always_comb begin
        s_d = s_q;
        if (bit_stb) begin
            s_d.line = tx_bit;
        end
        if (bit_stb && rx_bad) begin
            s_d.flag = 1'b1;
        end else if (viol_clr) begin
            s_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dout      = s_q.line;
    assign viol_flag = s_q.flag;

endmodule

// File: rtl/ones_density_guard_chk.sv
module ones_density_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_stb,
    input logic din,
    input logic enforce_en,
    input logic viol_clr,
    input logic dout,
    input logic viol_flag
);
    // R5
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb && !enforce_en |=> dout == $past(din));

    // R7
    ones_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb && din |=> dout);

    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_flag && !viol_clr |=> viol_flag);

    // R4
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_clr && !bit_stb |=> !viol_flag);

    // R9
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |=> $stable(dout));

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb && !viol_clr |=> $stable(viol_flag));

endmodule

bind ones_density_guard ones_density_guard_chk chk_i (.*);

// File: tb/ones_density_guard_test.sv
module ones_density_guard_test;
    localparam int CLK_PERIOD = 10;
    localparam int HIST = 192;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_stb = 1'b0, din = 1'b0, enforce_en = 1'b0, viol_clr = 1'b0;
    logic dout, viol_flag;

    int vectors = 0, fails = 0;
    bit done = 1'b0;

    // reference model state
    logic [HIST-1:0] ih, oh;
    int iseen, oseen;
    logic exp_flag, exp_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    ones_density_guard uut (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .din(din),
        .enforce_en(enforce_en), .viol_clr(viol_clr),
        .dout(dout), .viol_flag(viol_flag)
    );

    // would bit b, appended to history h, break any rule
    function automatic logic bad(input logic [HIST-1:0] h, input int seen, input logic b);
        int z, cnt, len;
        logic r, stop;
        r = 1'b0;
        if (!b) begin
            z = 1; stop = 1'b0;
            for (int i = 0; i < HIST; i++) begin
                if (!stop) begin
                    if (i >= seen || h[i]) stop = 1'b1;
                    else z++;
                end
            end
            if (z > 15) r = 1'b1;
        end
        for (int n = 1; n <= 23; n++) begin
            len = 8 * (n + 1);
            if (seen + 1 >= len) begin
                cnt = int'(b);
                for (int i = 0; i < len - 1; i++) cnt += int'(h[i]);
                if (cnt < n) r = 1'b1;
            end
        end
        return r;
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        ih = '0; oh = '0; iseen = 0; oseen = 0; exp_flag = 1'b0; exp_out = 1'b0;
    endtask

    task automatic do_reset();
        bit_stb = 1'b0; viol_clr = 1'b0; din = 1'b0;
        rst_n = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        chk(dout, 1'b0, "R10 dout");
        chk(viol_flag, 1'b0, "R10 flag");
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one strobe; called at a falling edge, returns at the next one
    task automatic send(input logic b, input logic en, input logic clr,
                        input string tout, input string tflag, input bit comply);
        logic in_bad;
        din = b; enforce_en = en; viol_clr = clr; bit_stb = 1'b1;
        in_bad  = bad(ih, iseen, b);
        exp_out = b | (en & bad(oh, oseen, 1'b0));
        if (in_bad) exp_flag = 1'b1;
        else if (clr) exp_flag = 1'b0;
        @(negedge clk);
        chk(dout, exp_out, tout);
        chk(viol_flag, exp_flag, tflag);
        if (comply) chk(bad(oh, oseen, dout), 1'b0, "R6 sent stream");
        ih = {ih[HIST-2:0], b};       iseen++;
        oh = {oh[HIST-2:0], exp_out}; oseen++;
    endtask

    // cycles without strobe; inputs wiggle, outputs must hold
    task automatic idle(input int n, input logic clr);
        logic hd, hf;
        bit_stb = 1'b0;
        for (int i = 0; i < n; i++) begin
            hd = dout; hf = viol_flag;
            din = 1'($urandom_range(0, 1));
            enforce_en = 1'($urandom_range(0, 1));
            viol_clr = (i == 0) ? clr : 1'b0;
            if (i == 0 && clr) exp_flag = 1'b0;
            @(negedge clk);
            chk(dout, hd, "R9 dout hold");
            chk(viol_flag, (i == 0 && clr) ? 1'b0 : hf, (i == 0 && clr) ? "R4 clear" : "R9 flag hold");
        end
        viol_clr = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5EED));
        @(negedge clk);
        do_reset();

        // start-up at each stretch's minimum: no flag (R3), pass-through (R5)
        for (int i = 0; i < 15; i++) send(1'b0, 1'b0, 1'b0, "R5", "R3", 1'b0);
        send(1'b1, 1'b0, 1'b0, "R5", "R3", 1'b0);
        for (int j = 0; j < 26; j++)
            for (int i = 0; i < 8; i++) send(i == 7, 1'b0, 1'b0, "R5", "R3", 1'b0);
        chk(viol_flag, 1'b0, "R3 no start-up flag");

        // zero run: 15 fine, 16th flags (R1)
        for (int i = 0; i < 15; i++) send(1'b0, 1'b0, 1'b0, "R5", "R1", 1'b0);
        chk(viol_flag, 1'b0, "R1 after 15 zeros");
        send(1'b0, 1'b0, 1'b0, "R5", "R1", 1'b0);
        chk(viol_flag, 1'b1, "R1 after 16 zeros");

        // sticky through good bits and idle, then clear (R4)
        for (int i = 0; i < 4; i++) send(1'b1, 1'b0, 1'b0, "R5", "R4 sticky", 1'b0);
        idle(3, 1'b0);
        idle(2, 1'b1);
        chk(viol_flag, 1'b0, "R4 cleared");
        for (int i = 0; i < 15; i++) send(1'b0, 1'b0, 1'b0, "R5", "R4", 1'b0);
        send(1'b0, 1'b0, 1'b1, "R5", "R4 set over clear", 1'b0);
        chk(viol_flag, 1'b1, "R4 set wins");

        // period-16 ones: short stretch limit broken (R2)
        idle(1, 1'b1);
        for (int j = 0; j < 12; j++)
            for (int i = 0; i < 16; i++) send(i == 0, 1'b0, 1'b0, "R5", "R2 p16", 1'b0);
        chk(viol_flag, 1'b1, "R2 period 16 flagged");

        // period-9 ones: only the long stretches are too thin (R2)
        idle(1, 1'b1);
        for (int j = 0; j < 30; j++)
            for (int i = 0; i < 9; i++) send(i == 0, 1'b0, 1'b0, "R5", "R2 p9", 1'b0);
        chk(viol_flag, 1'b1, "R2 period 9 flagged");

        // repair mode from reset: sparse random, then all zeros (R6 R7 R8)
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            send(($urandom_range(0, 11) == 0), 1'b1, ($urandom_range(0, 49) == 0),
                 "R7 repair", "R8 input judged", 1'b1);
            if ($urandom_range(0, 19) == 0) idle(int'($urandom_range(1, 3)), 1'b0);
        end
        for (int i = 0; i < 400; i++) send(1'b0, 1'b1, 1'b0, "R7 zeros", "R8", 1'b1);
        chk(viol_flag, 1'b1, "R8 flag on raw zeros under repair");

        // mode changes mid-stream, mixed density (R5 R7 R8)
        for (int i = 0; i < 2000; i++) begin
            send(($urandom_range(0, 6) == 0), ($urandom_range(0, 63) != 0) ^ (i >= 1000),
                 ($urandom_range(0, 29) == 0), "R5/R7 mixed", "R8 mixed", 1'b0);
            if ($urandom_range(0, 24) == 0) idle(2, 1'b0);
        end
        idle(4, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule